// File: doc/BRIEF.md
# Clock Generator Configuration Slave on SMBus

This block is the configuration port of a clock generator. A host on a two-wire SMBus segment reaches a small bank of 8-bit control registers through it. The host always names a starting register index. A write then carries a byte count and that many data bytes. A read, started after a repeated START, returns a count byte first and then data bytes from the index onward. Both SCL and SDA are oversampled with the system clock. The open-drain SDA pin appears as an output enable: 1 pulls the line low.

The bank holds the frequency-select and spread settings, the per-output enables and the per-output stop modes. It also holds a read-only copy of the strap inputs, fixed identification bytes and the read-back count. The strap-derived bits of the control register load from plain input pins once, when reset is released. Software may replace them only after it has set a select bit in the same register.

Top module: `clkcfg_smbus_regs`

## Requirements
- R1: The slave ACKs address byte 0xDC (write) and 0xDD (read). Any other address byte gets no ACK, and SDA stays released until the next START.
- R2: A write runs START, 0xDC, index, count, data bytes, STOP. The slave ACKs each byte, and data byte k goes to register index+k.
- R3: Once the count from the write header is used up, further data bytes are NACKed and not stored.
- R4: A read after a repeated START with 0xDD returns register 6 as a count byte, then registers index, index+1, and so on. This continues while the host ACKs and stops at the host NACK.
- R5: After reset, register 1 (output enables) is 0xFF, register 2 (stop modes) is 0x80, register 6 (count) is 0x07, and register 0 bits 2..1 are 0.
- R6: On reset release, register 0 loads from the straps: bits 7..4 from the frequency-select straps, bit 3 from the spread-enable strap, bit 0 from the spread-type strap.
- R7: Register 0 bits 2..1 (bit 2 software select, bit 1 stop drive mode) are always writable. Bits 7..3 and 0 take a write only while the stored bit 2 is 1.
- R8: Register 3 reads {fs straps, spread strap, 2'b00, type strap} as latched at reset. Writes and overrides leave it unchanged.
- R9: Register 4 reads {revision 4'h0, vendor 4'h1} = 0x01 and register 5 reads 0x07. Writes to registers 3..5 are ACKed and ignored.
- R10: Indices 7 and above read 0x00 and ignore writes. The index advances after every data byte.
- R11: SDA drive changes only while SCL is low, and it is released on every START and STOP.
- R12: The control outputs follow the registers: frequency select = reg0[7:4], spread enable = reg0[3], stop Hi-Z = reg0[1], spread center = reg0[0], output enables = reg1, stop modes = reg2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_fs_i | input | 4 | Frequency/input-select strap bits |
| strap_spread_en_i | input | 1 | Spread-enable strap |
| strap_spread_ctr_i | input | 1 | Spread-type strap (1 = center) |
| cfg_fs_o | output | 4 | Active frequency select |
| cfg_spread_en_o | output | 1 | Active spread enable |
| cfg_spread_ctr_o | output | 1 | Active spread type |
| cfg_stop_hiz_o | output | 1 | Stopped outputs float instead of driving |
| out_en_o | output | 8 | Per-output enables |
| stop_mode_o | output | 8 | Per-output stoppable flags |

## Verification
The bench first reads the whole bank from index 0. Against the straps this separates the reset values, the strap latch and the fixed identification bytes. Several writes then contrast the behaviour of the bank:
- Register 0 is written before and after the select bit is set, which shows the strap bits locked and then released.
- Writes land on the read-only registers, which must not change.
- Writes run past the last index, which must be dropped.
- A write sends more data bytes than its count, which must be NACKed past the count.

A foreign address checks that the slave stays silent. A read after the count register is rewritten shows that the count byte tracks the register and not the number of bytes read.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam logic [6:0] SLAVE_ADDR7  = 7'h6E;
  localparam logic [7:0] ADDR_WR_BYTE = {SLAVE_ADDR7, 1'b0};
  localparam logic [7:0] ADDR_RD_BYTE = {SLAVE_ADDR7, 1'b1};

  localparam int          NUM_REGS  = 7;
  localparam logic [7:0]  IDX_CTL   = 8'd0;
  localparam logic [7:0]  IDX_OE    = 8'd1;
  localparam logic [7:0]  IDX_STOPM = 8'd2;
  localparam logic [7:0]  IDX_STRAP = 8'd3;
  localparam logic [7:0]  IDX_ID    = 8'd4;
  localparam logic [7:0]  IDX_DEV   = 8'd5;
  localparam logic [7:0]  IDX_CNT   = 8'd6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_ACK_HOLD,
    ST_TX,
    ST_HACK,
    ST_TX_NEXT,
    ST_IGNORE
  } phase_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_INDEX,
    K_COUNT,
    K_DATA
  } kind_t;

endpackage

// File: rtl/clkcfg_bus_sampler.sv
module clkcfg_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sync_q, scl_sync_d;
  logic [TOP:0] sda_sync_q, sda_sync_d;
  logic         scl_prev_q, sda_prev_q;

  always_comb begin
    scl_sync_d = {scl_sync_q[TOP-1:0], scl_i};
    sda_sync_d = {sda_sync_q[TOP-1:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= scl_sync_d;
      sda_sync_q <= sda_sync_d;
      scl_prev_q <= scl_sync_q[TOP];
      sda_prev_q <= sda_sync_q[TOP];
    end
  end

  assign scl_lvl_o  = scl_sync_q[TOP];
  assign sda_lvl_o  = sda_sync_q[TOP];
  assign scl_rise_o = scl_lvl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_lvl_o & scl_prev_q;
  assign start_o    = scl_lvl_o & scl_prev_q & sda_prev_q & ~sda_lvl_o;
  assign stop_o     = scl_lvl_o & scl_prev_q & ~sda_prev_q & sda_lvl_o;

endmodule

// File: rtl/clkcfg_smbus_fsm.sv
module clkcfg_smbus_fsm
  import clkcfg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] count_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BYTE_W-1:0] rd_idx_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o,
  output logic              quiet_o
);

  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [BIT_W-1:0] ALL_BITS = BIT_W'(BYTE_W);

  phase_t            state_q, state_d;
  kind_t             kind_q, kind_d;
  logic              rd_mode_q, rd_mode_d;
  logic [BIT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] index_q, index_d;
  logic [BYTE_W-1:0] remain_q, remain_d;
  logic              sda_oe_q, sda_oe_d;
  logic              wr_en_q, wr_en_d;
  logic [BYTE_W-1:0] wr_idx_q, wr_idx_d;
  logic [BYTE_W-1:0] wr_data_q, wr_data_d;
  logic [BYTE_W-1:0] rx_byte;

  assign rx_byte = {shreg_q[BYTE_W-2:0], sda_lvl_i};

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    rd_mode_d = rd_mode_q;
    bitcnt_d  = bitcnt_q;
    shreg_d   = shreg_q;
    index_d   = index_q;
    remain_d  = remain_q;
    sda_oe_d  = sda_oe_q;
    wr_en_d   = 1'b0;
    wr_idx_d  = wr_idx_q;
    wr_data_d = wr_data_q;

    if (start_i) begin
      state_d  = ST_RX;
      kind_d   = K_ADDR;
      bitcnt_d = '0;
      sda_oe_d = 1'b0;
    end else if (stop_i) begin
      state_d  = ST_IDLE;
      sda_oe_d = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            shreg_d  = rx_byte;
            bitcnt_d = bitcnt_q + 1'b1;
            if (bitcnt_q == LAST_BIT) begin
              state_d = ST_ACK;
              case (kind_q)
                K_ADDR: begin
                  if (rx_byte == ADDR_WR_BYTE) begin
                    rd_mode_d = 1'b0;
                    kind_d    = K_INDEX;
                  end else if (rx_byte == ADDR_RD_BYTE) begin
                    rd_mode_d = 1'b1;
                  end else begin
                    state_d = ST_IGNORE;
                  end
                end
                K_INDEX: begin
                  index_d = rx_byte;
                  kind_d  = K_COUNT;
                end
                K_COUNT: begin
                  remain_d = rx_byte;
                  kind_d   = K_DATA;
                end
                default: begin
                  if (remain_q != '0) begin
                    wr_en_d   = 1'b1;
                    wr_idx_d  = index_q;
                    wr_data_d = rx_byte;
                    index_d   = index_q + 1'b1;
                    remain_d  = remain_q - 1'b1;
                  end else begin
                    state_d = ST_IGNORE;
                  end
                end
              endcase
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            sda_oe_d = 1'b1;
            state_d  = ST_ACK_HOLD;
          end
        end
        ST_ACK_HOLD: begin
          if (scl_fall_i) begin
            bitcnt_d = '0;
            if (rd_mode_q) begin
              state_d  = ST_TX;
              shreg_d  = count_i;
              sda_oe_d = ~count_i[BYTE_W-1];
            end else begin
              state_d  = ST_RX;
              sda_oe_d = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall_i) begin
            if (bitcnt_q == ALL_BITS) begin
              sda_oe_d = 1'b0;
              state_d  = ST_HACK;
            end else begin
              shreg_d  = {shreg_q[BYTE_W-2:0], 1'b0};
              sda_oe_d = ~shreg_q[BYTE_W-2];
            end
          end
        end
        ST_HACK: begin
          if (scl_rise_i) begin
            state_d = sda_lvl_i ? ST_IGNORE : ST_TX_NEXT;
          end
        end
        ST_TX_NEXT: begin
          if (scl_fall_i) begin
            shreg_d  = rd_data_i;
            sda_oe_d = ~rd_data_i[BYTE_W-1];
            index_d  = index_q + 1'b1;
            bitcnt_d = '0;
            state_d  = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= K_ADDR;
      rd_mode_q <= 1'b0;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      index_q   <= '0;
      remain_q  <= '0;
      sda_oe_q  <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      state_q   <= state_d;
      kind_q    <= kind_d;
      rd_mode_q <= rd_mode_d;
      bitcnt_q  <= bitcnt_d;
      shreg_q   <= shreg_d;
      index_q   <= index_d;
      remain_q  <= remain_d;
      sda_oe_q  <= sda_oe_d;
      wr_en_q   <= wr_en_d;
      wr_idx_q  <= wr_idx_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign rd_idx_o  = index_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign sda_oe_o  = sda_oe_q;
  assign quiet_o   = (state_q == ST_IDLE) || (state_q == ST_IGNORE);

endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank
  import clkcfg_pkg::*;
#(
  parameter logic [3:0] REV_ID      = 4'h0,
  parameter logic [3:0] VENDOR_ID   = 4'h1,
  parameter logic [7:0] DEVICE_ID   = 8'h07,
  parameter logic [7:0] CNT_RESET   = 8'h07,
  parameter logic [7:0] OE_RESET    = 8'hFF,
  parameter logic [7:0] STOPM_RESET = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] strap_fs_i,
  input  logic       strap_spread_en_i,
  input  logic       strap_spread_ctr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] rd_idx_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] ctl_o,
  output logic [7:0] oe_o,
  output logic [7:0] stopm_o,
  output logic [7:0] cnt_o
);

  localparam logic [7:0] ID_BYTE = {REV_ID, VENDOR_ID};

  logic [7:0] ctl_q, ctl_d;
  logic [7:0] oe_q, oe_d;
  logic [7:0] stm_q, stm_d;
  logic [7:0] cnt_q, cnt_d;
  logic [7:0] strap_q, strap_d;
  logic       latched_q, latched_d;

  always_comb begin
    ctl_d     = ctl_q;
    oe_d      = oe_q;
    stm_d     = stm_q;
    cnt_d     = cnt_q;
    strap_d   = strap_q;
    latched_d = 1'b1;
    if (!latched_q) begin
      ctl_d   = {strap_fs_i, strap_spread_en_i, ctl_q[2:1], strap_spread_ctr_i};
      strap_d = {strap_fs_i, strap_spread_en_i, 2'b00, strap_spread_ctr_i};
    end else if (wr_en_i) begin
      case (wr_idx_i)
        IDX_CTL:   ctl_d = ctl_q[2] ? wr_data_i
                                    : {ctl_q[7:3], wr_data_i[2:1], ctl_q[0]};
        IDX_OE:    oe_d  = wr_data_i;
        IDX_STOPM: stm_d = wr_data_i;
        IDX_CNT:   cnt_d = wr_data_i;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      oe_q      <= OE_RESET;
      stm_q     <= STOPM_RESET;
      cnt_q     <= CNT_RESET;
      strap_q   <= '0;
      latched_q <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      oe_q      <= oe_d;
      stm_q     <= stm_d;
      cnt_q     <= cnt_d;
      strap_q   <= strap_d;
      latched_q <= latched_d;
    end
  end

  always_comb begin
    case (rd_idx_i)
      IDX_CTL:   rd_data_o = ctl_q;
      IDX_OE:    rd_data_o = oe_q;
      IDX_STOPM: rd_data_o = stm_q;
      IDX_STRAP: rd_data_o = strap_q;
      IDX_ID:    rd_data_o = ID_BYTE;
      IDX_DEV:   rd_data_o = DEVICE_ID;
      IDX_CNT:   rd_data_o = cnt_q;
      default:   rd_data_o = 8'h00;
    endcase
  end

  assign ctl_o   = ctl_q;
  assign oe_o    = oe_q;
  assign stopm_o = stm_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/clkcfg_smbus_regs.sv
module clkcfg_smbus_regs #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [3:0] strap_fs_i,
  input  logic       strap_spread_en_i,
  input  logic       strap_spread_ctr_i,
  output logic [3:0] cfg_fs_o,
  output logic       cfg_spread_en_o,
  output logic       cfg_spread_ctr_o,
  output logic       cfg_stop_hiz_o,
  output logic [7:0] out_en_o,
  output logic [7:0] stop_mode_o
);

  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_idx, rd_data, wr_idx, wr_data, ctl, cnt;
  logic       wr_en, quiet, sw_sel;

  clkcfg_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_lvl_o  (scl_lvl),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  clkcfg_smbus_fsm #(.BYTE_W(8)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_lvl_i  (sda_lvl),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .count_i    (cnt),
    .rd_data_i  (rd_data),
    .rd_idx_o   (rd_idx),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o),
    .quiet_o    (quiet)
  );

  clkcfg_reg_bank u_bank (
    .clk                (clk),
    .rst_n              (rst_n),
    .strap_fs_i         (strap_fs_i),
    .strap_spread_en_i  (strap_spread_en_i),
    .strap_spread_ctr_i (strap_spread_ctr_i),
    .wr_en_i            (wr_en),
    .wr_idx_i           (wr_idx),
    .wr_data_i          (wr_data),
    .rd_idx_i           (rd_idx),
    .rd_data_o          (rd_data),
    .ctl_o              (ctl),
    .oe_o               (out_en_o),
    .stopm_o            (stop_mode_o),
    .cnt_o              (cnt)
  );

  assign cfg_fs_o         = ctl[7:4];
  assign cfg_spread_en_o  = ctl[3];
  assign sw_sel           = ctl[2];
  assign cfg_stop_hiz_o   = ctl[1];
  assign cfg_spread_ctr_o = ctl[0];

endmodule

// File: rtl/clkcfg_smbus_chk.sv
module clkcfg_smbus_chk
  import clkcfg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       quiet,
  input logic       wr_en,
  input logic [7:0] wr_idx,
  input logic       sw_sel,
  input logic [3:0] cfg_fs,
  input logic [7:0] out_en,
  input logic [7:0] stop_mode
);

  p_sda_low_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));

  p_release_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  p_release_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !sda_oe);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(out_en) && $stable(stop_mode)));

  p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= 8'(NUM_REGS))) |=>
      ($stable(out_en) && $stable(stop_mode) && $stable(cfg_fs)));

  p_fs_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sw_sel) |=> $stable(cfg_fs));

endmodule

bind clkcfg_smbus_regs clkcfg_smbus_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe_o),
  .quiet     (quiet),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .sw_sel    (sw_sel),
  .cfg_fs    (cfg_fs_o),
  .out_en    (out_en_o),
  .stop_mode (stop_mode_o)
);

// File: tb/clkcfg_smbus_regs_bench.sv
module clkcfg_smbus_regs_bench;

  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe;
  logic       sda_line;
  logic [3:0] cfg_fs;
  logic       cfg_spread_en, cfg_spread_ctr, cfg_stop_hiz;
  logic [7:0] out_en, stop_mode;

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  clkcfg_smbus_regs u_clkcfg_smbus_regs (
    .clk                (clk),
    .rst_n              (rst_n),
    .scl_i              (scl),
    .sda_i              (sda_line),
    .sda_oe_o           (sda_oe),
    .strap_fs_i         (4'b1011),
    .strap_spread_en_i  (1'b1),
    .strap_spread_ctr_i (1'b0),
    .cfg_fs_o           (cfg_fs),
    .cfg_spread_en_o    (cfg_spread_en),
    .cfg_spread_ctr_o   (cfg_spread_ctr),
    .cfg_stop_hiz_o     (cfg_stop_hiz),
    .out_en_o           (out_en),
    .stop_mode_o        (stop_mode)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_byte = 8'h00;
  logic       obs_stb = 1'b0;
  logic       watch_oe = 1'b0;
  logic       oe_seen = 1'b0;
  logic [3:0] scl_hist = 4'h0;
  logic       prev_oe = 1'b0;
  int         r11_viol = 0;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] d, input string tag);
    exp_q.push_back(d);
    tag_q.push_back(tag);
  endtask

  // monitor: compares each byte read from the slave against the scoreboard
  always @(posedge obs_stb) begin
    if (exp_q.size() == 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R4: unexpected byte actual %0h expected none", obs_byte);
    end else begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(32'(obs_byte), 32'(e), t);
    end
  end

  // R11 observer: slave drive must not move while SCL has been high
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && (&scl_hist)) r11_viol++;
    if (watch_oe && sda_oe) oe_seen = 1'b1;
    prev_oe  = sda_oe;
    scl_hist = {scl_hist[2:0], scl};
  end

  task automatic bus_start();
    m_sda = 1'b0; wait_clk(2*Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    m_sda = 1'b0; wait_clk(Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    m_sda = 1'b1; wait_clk(2*Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wait_clk(Q);
    scl = 1'b1; wait_clk(2*Q);
    scl = 1'b0; wait_clk(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    b = sda_line; wait_clk(Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic last);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(last);
    obs_byte = d;
    obs_stb = 1'b1;
    #1 obs_stb = 1'b0;
  endtask

  // data byte k in bits [8k+7:8k]; bytes past n_count must be NACKed (R3)
  task automatic reg_write(input logic [7:0] idx, input logic [31:0] data,
                           input int n_send, input int n_count);
    logic ack;
    bus_start();
    put_byte(8'hDC, ack); chk(32'(ack), 1, "R1 write address ACK");
    put_byte(idx, ack);   chk(32'(ack), 1, "R2 index ACK");
    put_byte(8'(n_count), ack); chk(32'(ack), 1, "R2 count ACK");
    for (int i = 0; i < n_send; i++) begin
      put_byte(data[8*i +: 8], ack);
      if (i < n_count) chk(32'(ack), 1, "R2 data ACK");
      else             chk(32'(ack), 0, "R3 data past count NACK");
    end
    bus_stop();
    wait_clk(4);
  endtask

  task automatic reg_read(input logic [7:0] idx, input int n_data);
    logic ack;
    bus_start();
    put_byte(8'hDC, ack); chk(32'(ack), 1, "R1 write address ACK");
    put_byte(idx, ack);   chk(32'(ack), 1, "R2 index ACK");
    bus_rstart();
    put_byte(8'hDD, ack); chk(32'(ack), 1, "R1 read address ACK");
    get_byte(n_data == 0);
    for (int i = 0; i < n_data; i++) get_byte(i == n_data - 1);
    bus_stop();
    wait_clk(4);
  endtask

  initial begin
    logic ack;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);

    // reset state
    chk(32'(out_en), 32'hFF, "R5 output enables reset");
    chk(32'(stop_mode), 32'h80, "R5 stop modes reset");
    chk(32'(cfg_stop_hiz), 0, "R5 stop drive mode reset");
    chk(32'(cfg_fs), 32'hB, "R6 frequency select from straps");
    chk(32'(cfg_spread_en), 1, "R6 spread enable from strap");
    chk(32'(cfg_spread_ctr), 0, "R6 spread type from strap");
    chk(32'(sda_oe), 0, "R11 SDA released after reset");

    // whole bank from index 0
    expect_byte(8'h07, "R4 count byte");
    expect_byte(8'hB8, "R6 reg0 strap latch");
    expect_byte(8'hFF, "R5 reg1 reset");
    expect_byte(8'h80, "R5 reg2 reset");
    expect_byte(8'hB8, "R8 reg3 strap copy");
    expect_byte(8'h01, "R9 reg4 id");
    expect_byte(8'h07, "R9 reg5 device");
    expect_byte(8'h07, "R5 reg6 count reset");
    reg_read(8'd0, 7);

    // two-byte block write to indices 1 and 2
    reg_write(8'd1, 32'h0000_3C5A, 2, 2);
    chk(32'(out_en), 32'h5A, "R12 output enables follow reg1");
    chk(32'(stop_mode), 32'h3C, "R12 stop modes follow reg2");
    expect_byte(8'h07, "R4 count byte");
    expect_byte(8'h5A, "R2 reg1 written");
    expect_byte(8'h3C, "R2 reg2 written");
    reg_read(8'd1, 2);

    // reg0 with select clear: only bits 2..1 land
    reg_write(8'd0, 32'h0000_00F2, 1, 1);
    chk(32'(cfg_fs), 32'hB, "R7 fs locked without select");
    chk(32'(cfg_spread_en), 1, "R7 spread locked without select");
    chk(32'(cfg_stop_hiz), 1, "R7 stop mode bit writable");
    reg_write(8'd0, 32'h0000_0004, 1, 1);
    expect_byte(8'h07, "R4 count byte");
    expect_byte(8'hBC, "R7 select set, straps kept");
    reg_read(8'd0, 1);
    reg_write(8'd0, 32'h0000_0095, 1, 1);
    chk(32'(cfg_fs), 32'h9, "R7 fs override");
    chk(32'(cfg_spread_en), 0, "R7 spread override");
    chk(32'(cfg_spread_ctr), 1, "R12 spread type follows reg0");
    chk(32'(cfg_stop_hiz), 0, "R12 stop drive follows reg0");

    // read-only registers ignore writes, strap copy unchanged
    reg_write(8'd3, 32'h00FF_FFFF, 3, 3);
    expect_byte(8'h07, "R4 count byte");
    expect_byte(8'hB8, "R8 strap copy after override");
    expect_byte(8'h01, "R9 id ignores write");
    expect_byte(8'h07, "R9 device ignores write");
    reg_read(8'd3, 3);

    // count register and writes past the last index
    reg_write(8'd6, 32'h0055_AA03, 3, 3);
    expect_byte(8'h03, "R4 count byte tracks reg6");
    expect_byte(8'h03, "R10 reg6 written");
    expect_byte(8'h00, "R10 index 7 reads zero");
    expect_byte(8'h00, "R10 index 8 reads zero");
    reg_read(8'd6, 3);

    // more data than the count
    reg_write(8'd2, 32'h0000_77E1, 2, 1);
    chk(32'(stop_mode), 32'hE1, "R3 only counted byte stored");

    // foreign address
    bus_start();
    watch_oe = 1'b1;
    put_byte(8'hA4, ack); chk(32'(ack), 0, "R1 foreign address NACK");
    put_byte(8'h00, ack); chk(32'(ack), 0, "R1 silent after foreign address");
    watch_oe = 1'b0;
    bus_stop();
    wait_clk(4);
    chk(32'(oe_seen), 0, "R1 SDA never driven after foreign address");
    expect_byte(8'h03, "R4 count byte");
    expect_byte(8'h5A, "R4 reg1 after foreign address");
    expect_byte(8'hE1, "R3 reg2 after NACK");
    reg_read(8'd1, 2);

    wait_clk(20);
    chk(32'(exp_q.size()), 0, "R4 every expected byte returned");
    chk(32'(r11_viol), 0, "R11 SDA moved only while SCL low");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule